// File: doc/BRIEF.md
# Circular Pointer Stepper

This unit moves a 16-bit address pointer forward or backward by 1, 2 or 4 while keeping it inside a circular buffer. The buffer size comes in as an operand alongside the pointer value. Wrapping works from the remainder of the pointer divided by the size, so the buffer may begin at any multiple of its size and needs no base or limit registers.

A decode stage presents the current pointer, the size, a step code, a direction bit and an operand-width code, then pulses `exec` for one cycle. One cycle later the unit presents the new pointer on `regOut` for the register file to write back, together with a one-cycle `done` pulse.

The operation is legal only on 16-bit operands with one of the three defined step codes. An illegal request, or a size of zero, returns the input pointer unchanged and raises a flag next to `done`. The unit produces no condition flags.

Top module: `mod_ptr_step`

## Requirements
- R1: After reset, `regOut` is 0 and `done`, `undef` and `sizeErr` are all low.
- R2: The result is registered. When `exec` is high in a cycle, `regOut` holds the result after the next rising clock edge, and `done` is high for exactly that one cycle.
- R3: In increment mode (`decMode`=0), when (value mod size) is not equal to (size − step), the result is value + step.
- R4: In increment mode, when (value mod size) equals (size − step), the result is value − (size − step), which wraps the pointer back to the start of its buffer.
- R5: In decrement mode (`decMode`=1), when (value mod size) is not zero, the result is value − step.
- R6: In decrement mode, when (value mod size) is zero, the result is value + (size − step), which wraps the pointer to the last slot of its buffer.
- R7: The step code `stepSel` selects the step: 0 gives 1, 1 gives 2, 2 gives 4. Code 3 is illegal. It raises `undef` with `done`, and `regOut` takes the input value unchanged.
- R8: The width code `widthSel` must be 1 (16-bit). Codes 0 (8-bit), 2 (32-bit) and 3 (reserved) raise `undef` with `done`, and `regOut` takes the input value unchanged. `undef` takes priority over `sizeErr`.
- R9: On a legal request with a size of zero, `sizeErr` rises with `done`, `regOut` takes the input value unchanged, and `undef` stays low.
- R10: While `exec` is low, `regOut` holds its value, and `done`, `undef` and `sizeErr` are low in the following cycle.
- R11: All additions and subtractions wrap modulo 2^16. For example, incrementing 0xFFFF by 1 with size 7 gives 0x0000, and decrementing 0x0001 by 4 with size 6 gives 0xFFFD.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| exec | input | 1 | One-cycle execute strobe |
| regIn | input | 16 | Current pointer value |
| sizeIn | input | 16 | Circular buffer size |
| stepSel | input | 2 | Step code: 0 = 1, 1 = 2, 2 = 4, 3 = illegal |
| decMode | input | 1 | 0 = increment, 1 = decrement |
| widthSel | input | 2 | Operand width code: 1 = 16-bit; all other codes are illegal |
| regOut | output | 16 | Updated pointer value |
| done | output | 1 | Result-valid pulse |
| undef | output | 1 | Illegal width or step code |
| sizeErr | output | 1 | Size operand was zero |

## Verification
The assertions check the timing and flag rules on every cycle. They confirm that `done` follows each strobe by exactly one cycle and never appears without one. They also confirm that the pointer stays put when no strobe arrives, that the two error flags never rise together or without `done`, and that a rejected request returns the input value. The wrap arithmetic itself (the remainder test, the exact wrap point for each step and direction, and the modulo-2^16 overflow) is shown only by the bench's scenarios. Those compare the output against values worked out from the rules for chosen and random pointers, with sizes that are multiples of the step.

// File: rtl/mps_pkg.sv
package mps_pkg;
  localparam int PTR_W  = 16;
  localparam int STEP_W = 2;
  localparam int WID_W  = 2;

  localparam logic [WID_W-1:0]  WID_LEGAL  = 2'd1;
  localparam logic [STEP_W-1:0] STEP_ONE   = 2'd0;
  localparam logic [STEP_W-1:0] STEP_TWO   = 2'd1;
  localparam logic [STEP_W-1:0] STEP_FOUR  = 2'd2;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;    // load a new value into the pointer register
    logic holdInput;  // load the input value unchanged
    logic flagUndef;  // illegal width or step code
    logic flagSize;   // zero size operand
  } mpsStrobes_t;

  function automatic logic [PTR_W-1:0] stepValue(input logic [STEP_W-1:0] code);
    case (code)
      STEP_ONE:  return PTR_W'(1);
      STEP_TWO:  return PTR_W'(2);
      STEP_FOUR: return PTR_W'(4);
      default:   return '0;
    endcase
  endfunction
endpackage

// File: rtl/mps_ctrl.sv
module mps_ctrl
  import mps_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              exec,
  input  logic [WID_W-1:0]  widthSel,
  input  logic [STEP_W-1:0] stepSel,
  input  logic              sizeZero,
  output mpsStrobes_t       strobes,
  output logic              done,
  output logic              undef,
  output logic              sizeErr
);
  logic illegalReq;

  always_comb begin
    illegalReq = (widthSel != WID_LEGAL) || (stepSel > STEP_FOUR);
    strobes.capture   = exec;
    strobes.flagUndef = exec && illegalReq;
    strobes.flagSize  = exec && !illegalReq && sizeZero;
    strobes.holdInput = exec && (illegalReq || sizeZero);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      done    <= 1'b0;
      undef   <= 1'b0;
      sizeErr <= 1'b0;
    end else begin
      done    <= strobes.capture;
      undef   <= strobes.flagUndef;
      sizeErr <= strobes.flagSize;
    end
  end

  // R2: a result follows every strobe
  a_r2_done_follows_exec: assert property (@(posedge clk) disable iff (!rstN)
    exec |=> done);
  // R10: no pulse without a strobe
  a_r10_idle_no_done: assert property (@(posedge clk) disable iff (!rstN)
    !exec |=> !done && !undef && !sizeErr);
  // R8: undef has priority, flags exclusive
  a_r8_flags_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({undef, sizeErr}));
  // R9: a flag only comes with done
  a_r9_flag_with_done: assert property (@(posedge clk) disable iff (!rstN)
    (undef || sizeErr) |-> done);
endmodule

// File: rtl/mps_datapath.sv
module mps_datapath
  import mps_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  mpsStrobes_t       strobes,
  input  logic [PTR_W-1:0]  regIn,
  input  logic [PTR_W-1:0]  sizeIn,
  input  logic [STEP_W-1:0] stepSel,
  input  logic              decMode,
  output logic              sizeZero,
  output logic [PTR_W-1:0]  regOut
);
  logic [PTR_W-1:0] stepVal;
  logic [PTR_W-1:0] divisor;
  logic [PTR_W-1:0] remainder;
  logic [PTR_W-1:0] gap;
  logic             atWrap;
  logic [PTR_W-1:0] nextVal;

  always_comb begin
    sizeZero  = (sizeIn == '0);
    divisor   = sizeZero ? PTR_W'(1) : sizeIn;   // keeps the divider defined
    stepVal   = stepValue(stepSel);
    remainder = regIn % divisor;
    gap       = sizeIn - stepVal;
    atWrap    = decMode ? (remainder == '0) : (remainder == gap);
    if (strobes.holdInput)
      nextVal = regIn;
    else if (decMode)
      nextVal = atWrap ? regIn + gap : regIn - stepVal;
    else
      nextVal = atWrap ? regIn - gap : regIn + stepVal;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                regOut <= '0;
    else if (strobes.capture) regOut <= nextVal;
  end

  // R10: pointer register holds without a strobe
  a_r10_hold_idle: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.capture |=> $stable(regOut));
  // R9: a rejected request returns the input value
  a_r9_reject_keeps_input: assert property (@(posedge clk) disable iff (!rstN)
    strobes.holdInput |=> regOut == $past(regIn));
endmodule

// File: rtl/mod_ptr_step.sv
module mod_ptr_step
  import mps_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              exec,
  input  logic [PTR_W-1:0]  regIn,
  input  logic [PTR_W-1:0]  sizeIn,
  input  logic [STEP_W-1:0] stepSel,
  input  logic              decMode,
  input  logic [WID_W-1:0]  widthSel,
  output logic [PTR_W-1:0]  regOut,
  output logic              done,
  output logic              undef,
  output logic              sizeErr
);
  mpsStrobes_t strobes;
  logic        sizeZero;

  mps_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .exec(exec), .widthSel(widthSel),
    .stepSel(stepSel), .sizeZero(sizeZero), .strobes(strobes),
    .done(done), .undef(undef), .sizeErr(sizeErr)
  );

  mps_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .regIn(regIn),
    .sizeIn(sizeIn), .stepSel(stepSel), .decMode(decMode),
    .sizeZero(sizeZero), .regOut(regOut)
  );
endmodule

// File: tb/tb_mod_ptr_step.sv
`timescale 1ns/1ps
module tb_mod_ptr_step;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        exec = 1'b0;
  logic [15:0] regIn = '0;
  logic [15:0] sizeIn = '0;
  logic [1:0]  stepSel = '0;
  logic        decMode = 1'b0;
  logic [1:0]  widthSel = 2'd1;
  logic [15:0] regOut;
  logic        done, undef, sizeErr;
  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  mod_ptr_step dut (.*);

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%04h expected=0x%04h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] refModel(input logic [15:0] v, input logic [15:0] s,
                                           input logic [1:0] sc, input logic dec);
    logic [15:0] st;
    st = (sc == 2'd0) ? 16'd1 : (sc == 2'd1) ? 16'd2 : 16'd4;
    if (dec) return ((v % s) == 16'd0) ? v + (s - st) : v - st;
    else     return ((v % s) == s - st) ? v - (s - st) : v + st;
  endfunction

  // one operation: drive on falling edge, sample on the following falling edge
  task automatic runOp(input logic [15:0] v, input logic [15:0] s, input logic [1:0] sc,
                       input logic dec, input logic [1:0] w);
    @(negedge clk);
    regIn = v; sizeIn = s; stepSel = sc; decMode = dec; widthSel = w; exec = 1'b1;
    @(negedge clk);
    exec = 1'b0;
  endtask

  task automatic testReset();
    check("R1 regOut", regOut, 16'h0);
    check("R1 done", {15'd0, done}, 16'd0);
    check("R1 undef", {15'd0, undef}, 16'd0);
    check("R1 sizeErr", {15'd0, sizeErr}, 16'd0);
  endtask

  task automatic testIncPlain();
    runOp(16'd10, 16'd8, 2'd0, 1'b0, 2'd1);
    check("R3 inc step1", regOut, 16'd11);
    check("R2 done pulse", {15'd0, done}, 16'd1);
    runOp(16'h0040, 16'd16, 2'd2, 1'b0, 2'd1);
    check("R3 inc step4", regOut, 16'h0044);
  endtask

  task automatic testIncWrap();
    runOp(16'h1007, 16'd8, 2'd0, 1'b0, 2'd1);
    check("R4 inc wrap step1", regOut, 16'h1000);
    runOp(16'd22, 16'd12, 2'd1, 1'b0, 2'd1);
    check("R4 inc wrap step2", regOut, 16'd12);
    runOp(16'h2014, 16'd8, 2'd2, 1'b0, 2'd1);
    check("R4 inc wrap step4", regOut, 16'h2010);
  endtask

  task automatic testDecPlain();
    runOp(16'h0105, 16'd16, 2'd1, 1'b1, 2'd1);
    check("R5 dec step2", regOut, 16'h0103);
  endtask

  task automatic testDecWrap();
    runOp(16'h0100, 16'd16, 2'd2, 1'b1, 2'd1);
    check("R6 dec wrap step4", regOut, 16'h010C);
    runOp(16'd30, 16'd10, 2'd0, 1'b1, 2'd1);
    check("R6 dec wrap step1", regOut, 16'd39);
  endtask

  task automatic testBadStep();
    runOp(16'h1234, 16'd8, 2'd3, 1'b0, 2'd1);
    check("R7 bad step keeps", regOut, 16'h1234);
    check("R7 undef", {15'd0, undef}, 16'd1);
    check("R7 done", {15'd0, done}, 16'd1);
  endtask

  task automatic testWidth();
    for (int w = 0; w < 4; w++) begin
      if (w == 1) continue;
      runOp(16'h0A00 + 16'(w), 16'd0, 2'd0, 1'b0, 2'(w));
      check("R8 bad width keeps", regOut, 16'h0A00 + 16'(w));
      check("R8 undef", {15'd0, undef}, 16'd1);
      check("R8 undef over sizeErr", {15'd0, sizeErr}, 16'd0);
    end
  endtask

  task automatic testSizeZero();
    runOp(16'h5555, 16'd0, 2'd1, 1'b1, 2'd1);
    check("R9 zero size keeps", regOut, 16'h5555);
    check("R9 sizeErr", {15'd0, sizeErr}, 16'd1);
    check("R9 no undef", {15'd0, undef}, 16'd0);
  endtask

  task automatic testHold();
    logic [15:0] held;
    runOp(16'd3, 16'd8, 2'd0, 1'b0, 2'd1);
    held = regOut;
    @(negedge clk);
    regIn = 16'hBEEF; sizeIn = 16'd4;
    @(negedge clk);
    check("R10 hold value", regOut, held);
    check("R10 done low", {15'd0, done}, 16'd0);
    check("R10 flags low", {14'd0, undef, sizeErr}, 16'd0);
  endtask

  task automatic testOverflow();
    runOp(16'hFFFF, 16'd7, 2'd0, 1'b0, 2'd1);
    check("R11 inc overflow", regOut, 16'h0000);
    runOp(16'h0001, 16'd6, 2'd2, 1'b1, 2'd1);
    check("R11 dec underflow", regOut, 16'hFFFD);
  endtask

  task automatic testRandom();
    for (int i = 0; i < 200; i++) begin
      logic [15:0] v, s;
      logic [1:0] sc;
      logic dec;
      sc  = 2'($urandom_range(0, 2));
      dec = 1'($urandom_range(0, 1));
      v   = 16'($urandom);
      s   = 16'($urandom_range(1, 60)) << sc;
      runOp(v, s, sc, dec, 2'd1);
      check(dec ? "R5/R6 random dec" : "R3/R4 random inc", regOut, refModel(v, s, sc, dec));
    end
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testIncPlain();
    testIncWrap();
    testDecPlain();
    testDecWrap();
    testBadStep();
    testWidth();
    testSizeZero();
    testHold();
    testOverflow();
    testRandom();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule